// File: doc/BRIEF.md
# Dual-Clock DDR Input Capture Register

This block takes one serial input that carries two data items per clock period and splits them onto two single-bit outputs for the core logic. Two capture clocks are used. A primary clock samples the item placed in the first half of each period. A secondary clock, normally the exact complement of the primary, samples the item placed in the second half.

A compile-time parameter picks one of three output alignments. In the opposite-edge alignment each output changes on its own capture clock. In the same-edge alignment the second-half item is retimed to the primary clock, so both outputs move together but the pairing is offset by one item. In the same-edge-pipelined alignment the first-half item is also retimed, so each period's two items appear together, one primary cycle later. A mode value outside these three stops elaboration with an error.

A clock enable freezes every stage, and an active-high reset clears every stage. A parameter chooses between synchronous and asynchronous reset. Power-up values of both outputs are set by parameters.

Top module: `ddr_in_cap`

## Requirements
- R1: With ALIGN_MODE = ALIGN_OPPOSITE (0), outRise shows the padData value sampled at the most recent enabled rising edge of clkPos, and outFall shows the value sampled at the most recent enabled rising edge of clkNeg.
- R2: With ALIGN_MODE = ALIGN_SAME (1), outRise shows the item sampled at the latest enabled clkPos edge, and outFall changes only on clkPos edges, where it takes the item sampled at the clkNeg edge before that clkPos edge. Each presentation therefore holds the first-half item of period n with the second-half item of period n-1.
- R3: With ALIGN_MODE = ALIGN_SAME_PIPE (2), one clkPos edge after the second-half item of period n is captured, outRise and outFall hold the first-half and second-half items of period n together. This is one primary cycle more latency on outRise than in R2.
- R4: While rst is high, outRise and outFall read 0. Every internal retiming stage is also cleared, so any slot that has no item captured since the release reads 0.
- R5: With ASYNC_RESET = 1, raising rst forces both outputs to 0 at once, with no clock edge needed.
- R6: With ASYNC_RESET = 0, raising rst leaves the outputs unchanged until the next rising edge of the clock that drives each output, which then clears it.
- R7: When capEn is low, no capture or retiming stage loads, so both outputs hold. When capEn returns high, the item pairing continues as if the low period had not occurred.
- R8: Reset takes priority over capEn: the outputs are cleared whatever the level of capEn.
- R9: Before any clock edge or reset, outRise equals parameter INIT_Q1 and outFall equals parameter INIT_Q2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkPos | input | 1 | Primary capture clock; its rising edge samples the first-half item |
| clkNeg | input | 1 | Secondary capture clock, normally the complement of clkPos; its rising edge samples the second-half item |
| capEn | input | 1 | Active-high enable for all capture and retiming stages |
| rst | input | 1 | Active-high reset, synchronous or asynchronous according to ASYNC_RESET |
| padData | input | 1 | Double-rate serial input |
| outRise | output | 1 | First-half item as presented by the selected alignment |
| outFall | output | 1 | Second-half item as presented by the selected alignment |

## Verification
Reset and enable can act in the same cycle. The bench raises rst once with capEn high and once with capEn low, and it expects zeros in both cases, because reset must win. The second coincidence is an asynchronous reset that lands in the middle of an enabled, data-carrying period. Before the next edge, the asynchronous instances must already read zero, while the synchronous instance must still show its last pair. On release, the first pair from each alignment is compared against a reference queue of the accepted items, in which every slot before the release counts as zero.

// File: rtl/ddr_in_cap_pkg.sv
`timescale 1ns/100ps
package ddr_in_cap_pkg;

  // Output alignment choices.
  typedef enum logic [1:0] {
    ALIGN_OPPOSITE  = 2'd0,
    ALIGN_SAME      = 2'd1,
    ALIGN_SAME_PIPE = 2'd2
  } alignMode_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic clear;
    logic load;
  } capStrobe_t;

endpackage

// File: rtl/ddr_in_cap_flop.sv
`timescale 1ns/100ps
// One enable flop. The reset style is picked by a parameter.
module ddr_in_cap_flop #(
  parameter bit ASYNC_RESET = 1'b1,
  parameter bit INIT_VAL    = 1'b0
) (
  input  logic clk,
  input  logic clear,
  input  logic load,
  input  logic d,
  output logic q
);

  logic state = INIT_VAL;

  generate
    if (ASYNC_RESET) begin : g_async
      always_ff @(posedge clk or posedge clear) begin
        if (clear)     state <= 1'b0;
        else if (load) state <= d;
      end
    end else begin : g_sync
      always_ff @(posedge clk) begin
        if (clear)     state <= 1'b0;
        else if (load) state <= d;
      end
    end
  endgenerate

  assign q = state;

endmodule

// File: rtl/ddr_in_cap_ctrl.sv
`timescale 1ns/100ps
// Turns the enable and the reset into the strobes the datapath uses.
module ddr_in_cap_ctrl
  import ddr_in_cap_pkg::*;
(
  input  logic       capEn,
  input  logic       rst,
  output capStrobe_t strobe
);

  always_comb begin
    strobe.clear = rst;
    // Reset wins over the enable.
    strobe.load  = capEn & ~rst;
  end

endmodule

// File: rtl/ddr_in_cap_dp.sv
`timescale 1ns/100ps
// Capture flops, plus the retiming flops the selected alignment needs.
module ddr_in_cap_dp
  import ddr_in_cap_pkg::*;
#(
  parameter alignMode_e ALIGN_MODE  = ALIGN_OPPOSITE,
  parameter bit         ASYNC_RESET = 1'b1,
  parameter bit         INIT_Q1     = 1'b0,
  parameter bit         INIT_Q2     = 1'b0
) (
  input  logic       clkPos,
  input  logic       clkNeg,
  input  capStrobe_t strobe,
  input  logic       padData,
  output logic       outRise,
  output logic       outFall
);

  localparam bit RETIME_FALL   = (ALIGN_MODE != ALIGN_OPPOSITE);
  localparam bit RETIME_RISE   = (ALIGN_MODE == ALIGN_SAME_PIPE);
  localparam bit RISE_CAP_INIT = RETIME_RISE ? 1'b0 : INIT_Q1;
  localparam bit FALL_CAP_INIT = RETIME_FALL ? 1'b0 : INIT_Q2;

  logic riseCap;
  logic fallCap;

  ddr_in_cap_flop #(.ASYNC_RESET(ASYNC_RESET), .INIT_VAL(RISE_CAP_INIT)) u_riseCap (
    .clk(clkPos), .clear(strobe.clear), .load(strobe.load), .d(padData), .q(riseCap)
  );

  ddr_in_cap_flop #(.ASYNC_RESET(ASYNC_RESET), .INIT_VAL(FALL_CAP_INIT)) u_fallCap (
    .clk(clkNeg), .clear(strobe.clear), .load(strobe.load), .d(padData), .q(fallCap)
  );

  generate
    if (RETIME_RISE) begin : g_riseRetime
      ddr_in_cap_flop #(.ASYNC_RESET(ASYNC_RESET), .INIT_VAL(INIT_Q1)) u_riseRetime (
        .clk(clkPos), .clear(strobe.clear), .load(strobe.load), .d(riseCap), .q(outRise)
      );
    end else begin : g_riseDirect
      assign outRise = riseCap;
    end

    if (RETIME_FALL) begin : g_fallRetime
      // Moves the second-half item into the primary clock domain.
      ddr_in_cap_flop #(.ASYNC_RESET(ASYNC_RESET), .INIT_VAL(INIT_Q2)) u_fallRetime (
        .clk(clkPos), .clear(strobe.clear), .load(strobe.load), .d(fallCap), .q(outFall)
      );
    end else begin : g_fallDirect
      assign outFall = fallCap;
    end
  endgenerate

endmodule

// File: rtl/ddr_in_cap.sv
`timescale 1ns/100ps
// Top level: a thin wrapper around the control and the datapath.
module ddr_in_cap
  import ddr_in_cap_pkg::*;
#(
  parameter alignMode_e ALIGN_MODE  = ALIGN_OPPOSITE,
  parameter bit         ASYNC_RESET = 1'b1,
  parameter bit         INIT_Q1     = 1'b0,
  parameter bit         INIT_Q2     = 1'b0
) (
  input  logic clkPos,
  input  logic clkNeg,
  input  logic capEn,
  input  logic rst,
  input  logic padData,
  output logic outRise,
  output logic outFall
);

  generate
    if (ALIGN_MODE > ALIGN_SAME_PIPE) begin : g_badMode
      $error("ddr_in_cap: ALIGN_MODE has an unsupported value");
    end
  endgenerate

  capStrobe_t strobe;

  ddr_in_cap_ctrl u_ctrl (
    .capEn (capEn),
    .rst   (rst),
    .strobe(strobe)
  );

  ddr_in_cap_dp #(
    .ALIGN_MODE (ALIGN_MODE),
    .ASYNC_RESET(ASYNC_RESET),
    .INIT_Q1    (INIT_Q1),
    .INIT_Q2    (INIT_Q2)
  ) u_dp (
    .clkPos (clkPos),
    .clkNeg (clkNeg),
    .strobe (strobe),
    .padData(padData),
    .outRise(outRise),
    .outFall(outFall)
  );

endmodule

// File: rtl/ddr_in_cap_chk.sv
`timescale 1ns/100ps
// Timing properties, checked at the ports of ddr_in_cap.
module ddr_in_cap_chk
  import ddr_in_cap_pkg::*;
#(
  parameter alignMode_e ALIGN_MODE = ALIGN_OPPOSITE
) (
  input logic clkPos,
  input logic clkNeg,
  input logic capEn,
  input logic rst,
  input logic padData,
  input logic outRise,
  input logic outFall
);

  // Checker-side record of the last enabled second-half sample.
  logic chkFall = 1'b0;
  always_ff @(posedge clkNeg) begin
    if (rst)        chkFall <= 1'b0;
    else if (capEn) chkFall <= padData;
  end

  // R7: a disabled primary edge leaves outRise as it was.
  p_rise_hold_r7: assert property (@(posedge clkPos) disable iff (rst)
    !capEn |=> $stable(outRise));

  generate
    if (ALIGN_MODE == ALIGN_OPPOSITE) begin : g_opp
      p_rise_capture_r1: assert property (@(posedge clkPos) disable iff (rst)
        capEn |=> (outRise == $past(padData)));
      p_fall_capture_r1: assert property (@(posedge clkNeg) disable iff (rst)
        capEn |=> (outFall == $past(padData)));
      p_fall_hold_r7: assert property (@(posedge clkNeg) disable iff (rst)
        !capEn |=> $stable(outFall));
    end else begin : g_sameClk
      p_fall_hold_r7: assert property (@(posedge clkPos) disable iff (rst)
        !capEn |=> $stable(outFall));
      // R2 / R3: outFall takes the item from the preceding secondary edge.
      p_fall_pair_r2: assert property (@(posedge clkPos) disable iff (rst)
        capEn |=> (outFall == $past(chkFall)));
      if (ALIGN_MODE == ALIGN_SAME) begin : g_same
        p_rise_capture_r2: assert property (@(posedge clkPos) disable iff (rst)
          capEn |=> (outRise == $past(padData)));
      end else begin : g_pipe
        p_rise_latency_r3: assert property (@(posedge clkPos) disable iff (rst)
          capEn ##1 capEn |=> (outRise == $past(padData, 2)));
      end
    end
  endgenerate

endmodule

bind ddr_in_cap ddr_in_cap_chk #(.ALIGN_MODE(ALIGN_MODE)) chk_i (
  .clkPos (clkPos),
  .clkNeg (clkNeg),
  .capEn  (capEn),
  .rst    (rst),
  .padData(padData),
  .outRise(outRise),
  .outFall(outFall)
);

// File: tb/ddr_in_cap_tb_top.sv
`timescale 1ns/100ps
module ddr_in_cap_tb_top;
  import ddr_in_cap_pkg::*;

  // 250 MHz primary clock; the secondary clock is its exact complement.
  logic clkPos = 1'b0;
  logic clkNeg;
  assign clkNeg = ~clkPos;
  always #2 clkPos = ~clkPos;

  logic rst = 1'b0;
  logic capEn = 1'b0;
  logic padData = 1'b0;
  logic oppRise, oppFall, sameRise, sameFall, pipeRise, pipeFall;

  ddr_in_cap #(.ALIGN_MODE(ALIGN_OPPOSITE), .ASYNC_RESET(1'b1), .INIT_Q1(1'b1), .INIT_Q2(1'b0)) dut_i (
    .clkPos(clkPos), .clkNeg(clkNeg), .capEn(capEn), .rst(rst), .padData(padData),
    .outRise(oppRise), .outFall(oppFall));

  ddr_in_cap #(.ALIGN_MODE(ALIGN_SAME), .ASYNC_RESET(1'b0), .INIT_Q1(1'b0), .INIT_Q2(1'b0)) dutSame_i (
    .clkPos(clkPos), .clkNeg(clkNeg), .capEn(capEn), .rst(rst), .padData(padData),
    .outRise(sameRise), .outFall(sameFall));

  ddr_in_cap #(.ALIGN_MODE(ALIGN_SAME_PIPE), .ASYNC_RESET(1'b1), .INIT_Q1(1'b0), .INIT_Q2(1'b1)) dutPipe_i (
    .clkPos(clkPos), .clkNeg(clkNeg), .capEn(capEn), .rst(rst), .padData(padData),
    .outRise(pipeRise), .outFall(pipeFall));

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  // Reference queue of the accepted items; a slot before the queue start reads 0.
  bit riseQ[256];
  bit fallQ[256];
  int cnt = 0;

  function automatic bit itemR(int idx);
    return (idx < 0) ? 1'b0 : riseQ[idx];
  endfunction

  function automatic bit itemF(int idx);
    return (idx < 0) ? 1'b0 : fallQ[idx];
  endfunction

  task automatic cmp(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  // Sampled 1 ns after a clkNeg edge.
  task automatic checkAll(string tag);
    cmp({tag, " R1 opposite rise"}, oppRise,  itemR(cnt - 1));
    cmp({tag, " R1 opposite fall"}, oppFall,  itemF(cnt - 1));
    cmp({tag, " R2 same rise"},     sameRise, itemR(cnt - 1));
    cmp({tag, " R2 same fall"},     sameFall, itemF(cnt - 2));
    cmp({tag, " R3 pipe rise"},     pipeRise, itemR(cnt - 2));
    cmp({tag, " R3 pipe fall"},     pipeFall, itemF(cnt - 2));
  endtask

  // Entered and left 1 ns after a clkNeg edge.
  task automatic runCycle(bit r, bit f, bit en);
    padData = r;
    capEn   = en;
    @(posedge clkPos);
    #1 padData = f;
    @(posedge clkNeg);
    #1;
    if (en && !rst && cnt < 256) begin
      riseQ[cnt] = r;
      fallQ[cnt] = f;
      cnt++;
    end
  endtask

  task automatic checkZero(string tag);
    cmp({tag, " opposite rise"}, oppRise, 1'b0);
    cmp({tag, " opposite fall"}, oppFall, 1'b0);
    cmp({tag, " same rise"},     sameRise, 1'b0);
    cmp({tag, " same fall"},     sameFall, 1'b0);
    cmp({tag, " pipe rise"},     pipeRise, 1'b0);
    cmp({tag, " pipe fall"},     pipeFall, 1'b0);
  endtask

  task automatic testInit();
    #1;
    cmp("R9 init opposite rise", oppRise, 1'b1);
    cmp("R9 init opposite fall", oppFall, 1'b0);
    cmp("R9 init same rise", sameRise, 1'b0);
    cmp("R9 init same fall", sameFall, 1'b0);
    cmp("R9 init pipe rise", pipeRise, 1'b0);
    cmp("R9 init pipe fall", pipeFall, 1'b1);
    @(posedge clkNeg);
    #1;
  endtask

  task automatic applyReset(bit enDuring);
    rst = 1'b1;
    runCycle(1'b1, 1'b1, enDuring);
    runCycle(1'b1, 1'b1, enDuring);
    checkZero(enDuring ? "R4 R8 reset with enable high" : "R4 R8 reset with enable low");
    rst = 1'b0;
    cnt = 0;
  endtask

  task automatic testStream();
    logic [7:0] lfsr = 8'hA5;
    applyReset(1'b1);
    // First pair after release: every empty slot must read 0.
    runCycle(1'b1, 1'b1, 1'b1);
    checkAll("R4 first pair after release");
    for (int i = 0; i < 24; i++) begin
      runCycle(lfsr[0], lfsr[3], 1'b1);
      checkAll("stream");
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    for (int i = 0; i < 6; i++) begin
      runCycle(i[0], ~i[0], 1'b1);
      checkAll("alternating");
    end
  endtask

  task automatic testEnableGap();
    runCycle(1'b1, 1'b0, 1'b1);
    runCycle(1'b0, 1'b1, 1'b1);
    checkAll("R7 before gap");
    for (int i = 0; i < 3; i++) begin
      runCycle(i[0], i[0], 1'b0);
      checkAll("R7 hold while disabled");
      cmp("R7 opposite rise holds", oppRise, 1'b0);
      cmp("R7 opposite fall holds", oppFall, 1'b1);
    end
    for (int i = 0; i < 4; i++) begin
      runCycle(1'b1, i[1], 1'b1);
      checkAll("R7 pairing after gap");
    end
  endtask

  task automatic testAsyncReset();
    runCycle(1'b1, 1'b1, 1'b1);
    runCycle(1'b1, 1'b1, 1'b1);
    checkAll("R5 R6 before reset");
    // Raise reset in the middle of an enabled period, between edges.
    rst = 1'b1;
    padData = 1'b1;
    #0.5;
    cmp("R5 async opposite rise", oppRise, 1'b0);
    cmp("R5 async opposite fall", oppFall, 1'b0);
    cmp("R5 async pipe rise", pipeRise, 1'b0);
    cmp("R5 async pipe fall", pipeFall, 1'b0);
    cmp("R6 sync same rise still held", sameRise, 1'b1);
    cmp("R6 sync same fall still held", sameFall, 1'b1);
    @(posedge clkPos);
    #0.5;
    cmp("R6 sync same rise cleared at edge", sameRise, 1'b0);
    cmp("R6 sync same fall cleared at edge", sameFall, 1'b0);
    @(posedge clkNeg);
    #1;
    checkZero("R4 R8 reset mid stream");
    rst = 1'b0;
    cnt = 0;
    for (int i = 0; i < 4; i++) begin
      runCycle(~i[0], 1'b1, 1'b1);
      checkAll("R4 after mid-stream reset");
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    testInit();
    applyReset(1'b0);
    testStream();
    testEnableGap();
    testAsyncReset();
    finished = 1'b1;
    report();
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired (all requirements): actual running expected done");
      report();
      $finish;
    end
  end

endmodule